// File: doc/BRIEF.md
# Dual-Plane Register File Access Unit

This block is the data-memory access stage of a small 8-bit core that has two register planes. The primary plane holds general file registers. It can be read and written by address, and its lower half also accepts single-bit set, clear and test operations. The secondary plane is a bank of write-only control registers. The only way to load them is to move a byte from the working register with a direct address, and their contents leave the block as a flat vector that the rest of the chip consumes.

Address 0 of the primary plane holds no storage. It is an indirection port. Any access to it is redirected to the location named by a pointer register, which itself sits in the primary plane at a fixed address. Reads and the bit-test result are combinational. Writes and bit modifications take effect at the clock edge that ends the access cycle. An operation the block refuses changes no state and raises a one-cycle error strobe.

Top module: `dpf_access`

## Requirements
- R1: After reset, every primary-plane location, every secondary register and `err_o` are zero.
- R2: A write (op 2) to primary plane (`plane_r_i`=0) address 1..127 updates that location at the clock edge. A read (op 1) returns the location on `rdata_o` combinationally in the same cycle.
- R3: A primary-plane access to address 0 uses bits [6:0] of the pointer register, which is primary location 4, as the effective address.
- R4: If the pointer register is 0, an indirect read returns 0 and an indirect write or bit operation changes no state.
- R5: A write (op 2) with `plane_r_i`=1 and address below 8 loads `wdata_i` into that secondary register. The register is visible on `r_plane_o` bits [8*a+7:8*a] after the edge, and the primary plane is not touched.
- R6: Read or bit operations on the secondary plane return 0 on `rdata_o`, change no state, and pulse `err_o` in the following cycle.
- R7: Bit set (op 3) and bit clear (op 4) on an effective primary address 1..63 change only bit `bit_i` of that location.
- R8: Bit test (op 5) on an effective primary address 1..63 drives `btest_o` with bit `bit_i` of that location combinationally.
- R9: A bit operation whose effective address is 64..127 is ignored. The location is unchanged, `btest_o` is 0, and `err_o` is high for exactly the next cycle.
- R10: A secondary-plane write to an address of 8 or more is ignored and pulses `err_o` in the following cycle.
- R11: A no-op (op 0) changes no state and leaves `err_o` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation: 0 nop, 1 read, 2 write, 3 bit set, 4 bit clear, 5 bit test |
| plane_r_i | input | 1 | 0 selects primary plane, 1 selects write-only plane |
| addr_i | input | 7 | Direct address |
| wdata_i | input | 8 | Write data (working register) |
| bit_i | input | 3 | Bit index for bit operations |
| rdata_o | output | 8 | Combinational read data |
| btest_o | output | 1 | Combinational bit-test result |
| err_o | output | 1 | One-cycle strobe for a refused operation |
| r_plane_o | output | 64 | Secondary register contents, register a at bits [8a+7:8a] |

## Verification
`rdata_o` and `btest_o` are due in the same cycle the operation is driven. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. Stored state and `err_o` are due one rising edge later, so they are sampled one nanosecond after that edge, while the same inputs are still held. State that a refused operation could have altered is read back by a later read, or observed on `r_plane_o`, before any further write.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_BSET  = 3'd3,
    OP_BCLR  = 3'd4,
    OP_BTEST = 3'd5
  } op_e;
endpackage

// File: rtl/dpf_resolve.sv
module dpf_resolve #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] ptr_i,
  output logic [AW-1:0] ea_o,
  output logic          null_o,
  output logic          lower_o
);
  // address 0 is the indirection port
  assign ea_o    = (addr_i == '0) ? ptr_i[AW-1:0] : addr_i;
  assign null_o  = (ea_o == '0);
  assign lower_o = ~ea_o[AW-1];
endmodule

// File: rtl/dpf_fplane.sv
module dpf_fplane #(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int PTR_ADDR = 4,
  localparam int DEPTH   = 2**AW,
  localparam int BW      = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          bset_i,
  input  logic          bclr_i,
  input  logic [AW-1:0] ea_i,
  input  logic [BW-1:0] bit_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] ptr_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[ea_i] <= wdata_i;
    end else if (bset_i) begin
      mem_q[ea_i][bit_i] <= 1'b1;
    end else if (bclr_i) begin
      mem_q[ea_i][bit_i] <= 1'b0;
    end
  end

  assign rd_data_o = mem_q[ea_i];
  assign ptr_o     = mem_q[PTR_ADDR];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(ea_i)] == $past(wdata_i));
  p_bset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bset_i && !wr_en_i) |=> mem_q[$past(ea_i)][$past(bit_i)] == 1'b1);
  p_bclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclr_i && !wr_en_i && !bset_i) |=> mem_q[$past(ea_i)][$past(bit_i)] == 1'b0);
  p_port0_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q[0] == '0);
endmodule

// File: rtl/dpf_rplane.sv
module dpf_rplane #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter int RN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [RN*DW-1:0] regs_o
);
  for (genvar g = 0; g < RN; g++) begin : g_reg
    logic [DW-1:0] reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                reg_q <= '0;
      else if (we_i && (int'(addr_i) == g))       reg_q <= wdata_i;
    end
    assign regs_o[g*DW +: DW] = reg_q;

    p_reg_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && int'(addr_i) == g) |=> regs_o[g*DW +: DW] == $past(wdata_i));
    p_reg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> $stable(regs_o[g*DW +: DW]));
  end
endmodule

// File: rtl/dpf_access.sv
module dpf_access
  import dpf_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int RN       = 8,
  parameter int PTR_ADDR = 4,
  localparam int BW      = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             plane_r_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [BW-1:0]    bit_i,
  output logic [DW-1:0]    rdata_o,
  output logic             btest_o,
  output logic             err_o,
  output logic [RN*DW-1:0] r_plane_o
);
  op_e           op;
  logic [AW-1:0] ea;
  logic          ea_null, ea_lower;
  logic [DW-1:0] ptr, f_data;
  logic          on_f, is_bitop;
  logic          f_rd, f_wr, f_set, f_clr, f_tst, bit_ok, bit_bad;
  logic          r_wr_ok, r_bad, err_d, err_q;

  assign op = op_e'(op_i);

  dpf_resolve #(.AW(AW), .DW(DW)) u_resolve (
    .addr_i (addr_i),
    .ptr_i  (ptr),
    .ea_o   (ea),
    .null_o (ea_null),
    .lower_o(ea_lower)
  );

  assign on_f     = ~plane_r_i;
  assign is_bitop = (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BTEST);
  assign f_rd     = on_f && (op == OP_READ);
  assign f_wr     = on_f && (op == OP_WRITE) && !ea_null;
  assign bit_ok   = on_f && is_bitop && ea_lower && !ea_null;
  assign bit_bad  = on_f && is_bitop && !ea_lower;
  assign f_set    = bit_ok && (op == OP_BSET);
  assign f_clr    = bit_ok && (op == OP_BCLR);
  assign f_tst    = bit_ok && (op == OP_BTEST);

  assign r_wr_ok  = plane_r_i && (op == OP_WRITE) && (int'(addr_i) < RN);
  assign r_bad    = plane_r_i && ((op == OP_READ) || is_bitop ||
                                  ((op == OP_WRITE) && (int'(addr_i) >= RN)));
  assign err_d    = bit_bad || r_bad;

  dpf_fplane #(.AW(AW), .DW(DW), .PTR_ADDR(PTR_ADDR)) u_fplane (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (f_wr),
    .bset_i   (f_set),
    .bclr_i   (f_clr),
    .ea_i     (ea),
    .bit_i    (bit_i),
    .wdata_i  (wdata_i),
    .rd_data_o(f_data),
    .ptr_o    (ptr)
  );

  dpf_rplane #(.AW(AW), .DW(DW), .RN(RN)) u_rplane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (r_wr_ok),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .regs_o (r_plane_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o   = err_q;
  assign rdata_o = f_rd ? f_data : '0;
  assign btest_o = f_tst ? f_data[bit_i] : 1'b0;

  p_upper_bit_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_bad |=> err_o);
  p_upper_btest_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_bad |-> !btest_o);
  p_rplane_no_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plane_r_i |-> rdata_o == '0);
  p_null_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_f && op == OP_READ && addr_i == '0 && ptr[AW-1:0] == '0) |-> rdata_o == '0);
  p_nop_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |=> (!err_o && $stable(r_plane_o)));
  p_rplane_bad_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plane_r_i && op_i == 3'd2 && int'(addr_i) >= RN) |=> (err_o && $stable(r_plane_o)));
endmodule

// File: tb/dpf_access_bench.sv
module dpf_access_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = '0;
  logic        plane_r = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [2:0]  bidx = '0;
  logic [7:0]  rdata;
  logic        btest, err;
  logic [63:0] rplane;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] c_rdata;
  logic       c_btest, c_err;

  localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, BS = 3'd3, BC = 3'd4, BT = 3'd5;

  always #2.5 clk = ~clk;

  dpf_access u_dpf_access (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .plane_r_i(plane_r), .addr_i(addr),
    .wdata_i(wdata), .bit_i(bidx), .rdata_o(rdata), .btest_o(btest),
    .err_o(err), .r_plane_o(rplane)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, capture comb outputs before rising edge, err after it
  task automatic apply(input logic [2:0] o, input logic pr, input logic [6:0] a,
                       input logic [7:0] d, input logic [2:0] b);
    @(negedge clk);
    op = o; plane_r = pr; addr = a; wdata = d; bidx = b;
    #1;
    c_rdata = rdata; c_btest = btest;
    @(posedge clk);
    #1;
    c_err = err;
  endtask

  task automatic f_read(input logic [6:0] a, output logic [7:0] v);
    apply(RD, 1'b0, a, 8'h00, 3'd0);
    v = c_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 err", {63'd0, err}, 64'd0);
    check("R1 rplane", rplane, 64'd0);
    f_read(7'd1, v);   check("R1 loc1", {56'd0, v}, 64'd0);
    f_read(7'd127, v); check("R1 loc127", {56'd0, v}, 64'd0);
  endtask

  task automatic t_direct;
    logic [7:0] v;
    apply(WR, 1'b0, 7'd10, 8'h5A, 3'd0);
    f_read(7'd10, v);  check("R2 loc10", {56'd0, v}, 64'h5A);
    apply(WR, 1'b0, 7'd127, 8'hC3, 3'd0);
    f_read(7'd127, v); check("R2 loc127", {56'd0, v}, 64'hC3);
    f_read(7'd11, v);  check("R2 neighbour", {56'd0, v}, 64'd0);
  endtask

  task automatic t_indirect;
    logic [7:0] v;
    apply(WR, 1'b0, 7'd4, 8'd20, 3'd0);
    apply(WR, 1'b0, 7'd0, 8'h77, 3'd0);
    f_read(7'd20, v); check("R3 target written", {56'd0, v}, 64'h77);
    f_read(7'd0, v);  check("R3 indirect read", {56'd0, v}, 64'h77);
    apply(WR, 1'b0, 7'd4, 8'd4, 3'd0);
    f_read(7'd0, v);  check("R3 pointer to itself", {56'd0, v}, 64'd4);
  endtask

  task automatic t_null;
    logic [7:0] v;
    apply(WR, 1'b0, 7'd4, 8'd0, 3'd0);
    apply(WR, 1'b0, 7'd0, 8'hFF, 3'd0);
    f_read(7'd0, v);  check("R4 null read", {56'd0, v}, 64'd0);
    apply(BS, 1'b0, 7'd0, 8'h00, 3'd1);
    check("R4 null bitop no err", {63'd0, c_err}, 64'd0);
    f_read(7'd4, v);  check("R4 pointer untouched", {56'd0, v}, 64'd0);
    f_read(7'd10, v); check("R4 loc10 untouched", {56'd0, v}, 64'h5A);
  endtask

  task automatic t_rplane;
    logic [7:0] v;
    apply(WR, 1'b1, 7'd3, 8'h9C, 3'd0);
    check("R5 r3 loaded", {56'd0, rplane[31:24]}, 64'h9C);
    check("R5 no err", {63'd0, c_err}, 64'd0);
    apply(WR, 1'b1, 7'd7, 8'h11, 3'd0);
    check("R5 r7 loaded", rplane, 64'h1100_0000_9C00_0000);
    f_read(7'd3, v); check("R5 primary untouched", {56'd0, v}, 64'd0);
  endtask

  task automatic t_rplane_bad;
    apply(RD, 1'b1, 7'd3, 8'h00, 3'd0);
    check("R6 read data zero", {56'd0, c_rdata}, 64'd0);
    check("R6 err", {63'd0, c_err}, 64'd1);
    apply(BS, 1'b1, 7'd3, 8'h00, 3'd0);
    check("R6 bitop err", {63'd0, c_err}, 64'd1);
    check("R6 state kept", rplane, 64'h1100_0000_9C00_0000);
    apply(WR, 1'b1, 7'd8, 8'hEE, 3'd0);
    check("R10 err", {63'd0, c_err}, 64'd1);
    check("R10 state kept", rplane, 64'h1100_0000_9C00_0000);
  endtask

  task automatic t_bitops;
    logic [7:0] v;
    apply(WR, 1'b0, 7'd30, 8'h0F, 3'd0);
    apply(BS, 1'b0, 7'd30, 8'h00, 3'd6);
    f_read(7'd30, v); check("R7 bit set", {56'd0, v}, 64'h4F);
    apply(BC, 1'b0, 7'd30, 8'h00, 3'd0);
    f_read(7'd30, v); check("R7 bit clear", {56'd0, v}, 64'h4E);
    apply(BT, 1'b0, 7'd30, 8'h00, 3'd6);
    check("R8 test one", {63'd0, c_btest}, 64'd1);
    apply(BT, 1'b0, 7'd30, 8'h00, 3'd0);
    check("R8 test zero", {63'd0, c_btest}, 64'd0);
    apply(WR, 1'b0, 7'd4, 8'd30, 3'd0);
    apply(BS, 1'b0, 7'd0, 8'h00, 3'd7);
    f_read(7'd30, v); check("R7 indirect set", {56'd0, v}, 64'hCE);
    apply(BS, 1'b0, 7'd63, 8'h00, 3'd2);
    check("R7 loc63 no err", {63'd0, c_err}, 64'd0);
    f_read(7'd63, v); check("R7 loc63 set", {56'd0, v}, 64'h04);
  endtask

  task automatic t_upper;
    logic [7:0] v;
    apply(WR, 1'b0, 7'd100, 8'h00, 3'd0);
    apply(BS, 1'b0, 7'd100, 8'h00, 3'd2);
    check("R9 err on set", {63'd0, c_err}, 64'd1);
    f_read(7'd100, v); check("R9 loc100 kept", {56'd0, v}, 64'd0);
    check("R9 err one cycle", {63'd0, c_err}, 64'd0);
    apply(WR, 1'b0, 7'd64, 8'hFF, 3'd0);
    apply(BT, 1'b0, 7'd64, 8'h00, 3'd5);
    check("R9 btest upper zero", {63'd0, c_btest}, 64'd0);
    check("R9 err on test", {63'd0, c_err}, 64'd1);
    apply(BC, 1'b0, 7'd64, 8'h00, 3'd5);
    f_read(7'd64, v); check("R9 loc64 kept", {56'd0, v}, 64'hFF);
  endtask

  task automatic t_nop;
    logic [7:0] v;
    apply(NOP, 1'b1, 7'd3, 8'hAA, 3'd1);
    check("R11 no err", {63'd0, c_err}, 64'd0);
    check("R11 rplane kept", rplane, 64'h1100_0000_9C00_0000);
    apply(NOP, 1'b0, 7'd10, 8'hAA, 3'd1);
    f_read(7'd10, v); check("R11 loc10 kept", {56'd0, v}, 64'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_indirect();
    t_null();
    t_rplane();
    t_rplane_bad();
    t_bitops();
    t_upper();
    t_nop();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule